// File: doc/BRIEF.md
# Threshold Offset Load Sequencer

This block holds the two threshold values a buffer uses to raise its almost-empty and almost-full indications, and lets them be written and read back through the buffer's ordinary data ports. No address is involved. A single load select turns the next write or read accesses into threshold accesses. A small sequencer on each side steps through the two thresholds in a fixed order. The empty-side threshold always comes first and the full-side threshold second.

The write side runs on the write clock and captures the low bits of the data input. The read side runs on the read clock and returns the selected threshold in the low bits of a readback word. When load is low, the enables pass through as the buffer's push and pop strobes. When load is high, those strobes are held off so that the storage pointers stay where they are. Every access is accepted in the cycle it is presented, so there is no back-pressure at either edge of the block. The thresholds are meant to be programmed while the read side is idle, because the read side samples them without synchronisation.

Top module: `ofs_load_seq`

## Requirements
- R1: While rst_n is low, and just after it rises, empty_ofs equals DEF_EMPTY, full_ofs equals DEF_FULL, rd_word is all zeros, and both sequencers point at the empty-side threshold.
- R2: On a rising wclk edge with load=1 and wr_en=1, wr_data[OFS_W-1:0] is stored into the threshold the write sequencer selects, and the other threshold keeps its value.
- R3: Threshold writes with load held at 1 go to empty_ofs first, then to full_ofs, then wrap back to empty_ofs.
- R4: A wclk edge with load=1 and wr_en=0 changes neither threshold and does not step the write sequencer.
- R5: A wclk edge with load=0 changes neither threshold, whatever wr_en is.
- R6: A clock edge that samples load=0 returns that clock's sequencer to the empty-side threshold.
- R7: On a rising rclk edge with load=1 and rd_en=1, rd_word takes the selected threshold in bits OFS_W-1:0 and zeros above them. The read sequencer then steps in the same order as in R3.
- R8: rd_word keeps its value on any rclk edge without load=1 and rd_en=1.
- R9: fifo_push equals wr_en and fifo_pop equals rd_en while load=0. Both are 0 while load=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | 1 turns accesses into threshold accesses |
| wr_en | input | 1 | Write enable, active high |
| rd_en | input | 1 | Read enable, active high |
| wr_data | input | DATA_W | Data input; low OFS_W bits feed the thresholds |
| empty_ofs | output | OFS_W | Almost-empty threshold |
| full_ofs | output | OFS_W | Almost-full threshold |
| rd_word | output | DATA_W | Readback word |
| fifo_push | output | 1 | Write strobe to the buffer storage |
| fifo_pop | output | 1 | Read strobe to the buffer storage |

## Verification
The bench builds the block with OFS_W=12, DATA_W=18, DEF_EMPTY=31 and DEF_FULL=63. With two different reset defaults, a write or readback that lands on the wrong threshold is visible straight after reset. With DATA_W wider than OFS_W, the zero padding of rd_word and the masking of the upper input bits are both exercised. Both clocks run in phase, so a threshold read and a threshold write can fall on the same edge, and the bench expects the readback to return the value held before that edge.

// File: rtl/ofs_load_pkg.sv
package ofs_load_pkg;
  typedef enum logic {SEL_EMPTY = 1'b0, SEL_FULL = 1'b1} ofs_sel_e;
endpackage

// File: rtl/ofs_seq.sv
module ofs_seq
  import ofs_load_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load,
  input  logic     access,
  output ofs_sel_e sel
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel <= SEL_EMPTY;
    else if (!load)  sel <= SEL_EMPTY;
    else if (access) sel <= (sel == SEL_EMPTY) ? SEL_FULL : SEL_EMPTY;
  end
endmodule

// File: rtl/ofs_regs.sv
module ofs_regs
  import ofs_load_pkg::*;
#(
  parameter int OFS_W     = 12,
  parameter int DEF_EMPTY = 127,
  parameter int DEF_FULL  = 127
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  ofs_sel_e         sel,
  input  logic [OFS_W-1:0] din,
  output logic [OFS_W-1:0] empty_ofs,
  output logic [OFS_W-1:0] full_ofs
);
  localparam int NREG = 2;
  logic [OFS_W-1:0] regs [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [OFS_W-1:0] RST_VAL = (i == 0) ? OFS_W'(DEF_EMPTY) : OFS_W'(DEF_FULL);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           regs[i] <= RST_VAL;
      else if (we && (int'(sel) == i))      regs[i] <= din;
    end
  end

  assign empty_ofs = regs[0];
  assign full_ofs  = regs[1];
endmodule

// File: rtl/ofs_readback.sv
module ofs_readback
  import ofs_load_pkg::*;
#(
  parameter int OFS_W  = 12,
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              re,
  input  ofs_sel_e          sel,
  input  logic [OFS_W-1:0]  empty_ofs,
  input  logic [OFS_W-1:0]  full_ofs,
  output logic [DATA_W-1:0] rd_word
);
  localparam int PAD_W = DATA_W - OFS_W;
  logic [OFS_W-1:0] pick;

  assign pick = (sel == SEL_EMPTY) ? empty_ofs : full_ofs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rd_word <= '0;
    else if (re) rd_word <= {{PAD_W{1'b0}}, pick};
  end
endmodule

// File: rtl/ofs_load_seq.sv
module ofs_load_seq
  import ofs_load_pkg::*;
#(
  parameter int OFS_W     = 12,
  parameter int DATA_W    = 18,
  parameter int DEF_EMPTY = 127,
  parameter int DEF_FULL  = 127
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [OFS_W-1:0]  empty_ofs,
  output logic [OFS_W-1:0]  full_ofs,
  output logic [DATA_W-1:0] rd_word,
  output logic              fifo_push,
  output logic              fifo_pop
);
  ofs_sel_e wsel, rsel;
  logic     ld_wr, ld_rd;

  assign ld_wr     = load & wr_en;
  assign ld_rd     = load & rd_en;
  assign fifo_push = ~load & wr_en;
  assign fifo_pop  = ~load & rd_en;

  ofs_seq u_wseq (.clk(wclk), .rst_n(rst_n), .load(load), .access(wr_en), .sel(wsel));
  ofs_seq u_rseq (.clk(rclk), .rst_n(rst_n), .load(load), .access(rd_en), .sel(rsel));

  ofs_regs #(.OFS_W(OFS_W), .DEF_EMPTY(DEF_EMPTY), .DEF_FULL(DEF_FULL)) u_regs (
    .clk(wclk), .rst_n(rst_n), .we(ld_wr), .sel(wsel), .din(wr_data[OFS_W-1:0]),
    .empty_ofs(empty_ofs), .full_ofs(full_ofs)
  );

  ofs_readback #(.OFS_W(OFS_W), .DATA_W(DATA_W)) u_rb (
    .clk(rclk), .rst_n(rst_n), .re(ld_rd), .sel(rsel),
    .empty_ofs(empty_ofs), .full_ofs(full_ofs), .rd_word(rd_word)
  );
endmodule

// File: rtl/ofs_load_seq_chk.sv
module ofs_load_seq_chk #(
  parameter int OFS_W  = 12,
  parameter int DATA_W = 18
) (
  input logic              wclk,
  input logic              rclk,
  input logic              rst_n,
  input logic              load,
  input logic              wr_en,
  input logic              rd_en,
  input logic [OFS_W-1:0]  empty_ofs,
  input logic [OFS_W-1:0]  full_ofs,
  input logic [DATA_W-1:0] rd_word,
  input logic              fifo_push,
  input logic              fifo_pop
);
  assert_hold_when_idle_R4: assert property (@(posedge wclk) disable iff (!rst_n)
    !(load && wr_en) |=> ($stable(empty_ofs) && $stable(full_ofs)));

  assert_one_target_R2: assert property (@(posedge wclk) disable iff (!rst_n)
    (load && wr_en) |=> ($stable(empty_ofs) || $stable(full_ofs)));

  assert_rd_hold_R8: assert property (@(posedge rclk) disable iff (!rst_n)
    !(load && rd_en) |=> $stable(rd_word));

  assert_rd_pad_R7: assert property (@(posedge rclk) disable iff (!rst_n)
    rd_word[DATA_W-1:OFS_W] == '0);

  assert_strobes_gated_R9: assert property (@(posedge wclk) disable iff (!rst_n)
    load |-> (!fifo_push && !fifo_pop));
endmodule

bind ofs_load_seq ofs_load_seq_chk #(.OFS_W(OFS_W), .DATA_W(DATA_W)) u_chk (
  .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .load(load), .wr_en(wr_en), .rd_en(rd_en),
  .empty_ofs(empty_ofs), .full_ofs(full_ofs), .rd_word(rd_word),
  .fifo_push(fifo_push), .fifo_pop(fifo_pop)
);

// File: tb/ofs_load_seq_bench.sv
`timescale 1ns/1ps
module ofs_load_seq_bench;
  localparam int OFS_W = 12, DATA_W = 18, DEF_E = 31, DEF_F = 63;

  logic clk = 1'b0;
  logic rst_n, load, wr_en, rd_en;
  logic [DATA_W-1:0] wr_data;
  logic [OFS_W-1:0]  empty_ofs, full_ofs;
  logic [DATA_W-1:0] rd_word;
  logic fifo_push, fifo_pop;

  int n_cmp = 0, n_bad = 0;
  logic [OFS_W-1:0]  me, mf;
  logic [DATA_W-1:0] mrd;
  bit mws, mrs;

  always #2.5 clk = ~clk;

  ofs_load_seq #(.OFS_W(OFS_W), .DATA_W(DATA_W), .DEF_EMPTY(DEF_E), .DEF_FULL(DEF_F)) u_ofs_load_seq (
    .wclk(clk), .rclk(clk), .rst_n(rst_n), .load(load), .wr_en(wr_en), .rd_en(rd_en),
    .wr_data(wr_data), .empty_ofs(empty_ofs), .full_ofs(full_ofs), .rd_word(rd_word),
    .fifo_push(fifo_push), .fifo_pop(fifo_pop)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] rb_val(bit s, logic [OFS_W-1:0] e, logic [OFS_W-1:0] f);
    return DATA_W'(s ? f : e);
  endfunction

  // one cycle: drive at negedge, model the edge, compare at the next negedge
  task automatic cycle(string tag, bit l, bit w, bit r, logic [DATA_W-1:0] d);
    logic [DATA_W-1:0] nrd;
    load = l; wr_en = w; rd_en = r; wr_data = d;
    #1;
    chk({tag, "/R9 push"}, 32'(fifo_push), 32'(w & ~l));
    chk({tag, "/R9 pop"},  32'(fifo_pop),  32'(r & ~l));
    nrd = (l && r) ? rb_val(mrs, me, mf) : mrd;
    if (l && w) begin
      if (mws) mf = d[OFS_W-1:0]; else me = d[OFS_W-1:0];
    end
    mrd = nrd;
    mws = l ? (w ? ~mws : mws) : 1'b0;
    mrs = l ? (r ? ~mrs : mrs) : 1'b0;
    @(negedge clk);
    chk({tag, "/R2 empty_ofs"}, 32'(empty_ofs), 32'(me));
    chk({tag, "/R2 full_ofs"},  32'(full_ofs),  32'(mf));
    chk({tag, "/R7 rd_word"},   32'(rd_word),   32'(mrd));
  endtask

  initial begin
    rst_n = 1'b0; load = 1'b0; wr_en = 1'b0; rd_en = 1'b0; wr_data = '0;
    me = OFS_W'(DEF_E); mf = OFS_W'(DEF_F); mrd = '0; mws = 1'b0; mrs = 1'b0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1 empty_ofs in reset", 32'(empty_ofs), DEF_E);
    chk("R1 full_ofs in reset", 32'(full_ofs), DEF_F);
    chk("R1 rd_word in reset", 32'(rd_word), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: readback right after reset gives defaults in order empty, full
    cycle("R1 rb0", 1, 0, 1, '0);
    cycle("R1 rb1", 1, 0, 1, '0);
    cycle("R6 release", 0, 0, 0, '0);
    // R3: write order empty, full, then wrap to empty
    cycle("R3 w0", 1, 1, 0, 18'h3_0ABC);
    cycle("R3 w1", 1, 1, 0, 18'h2_0123);
    cycle("R3 wrap", 1, 1, 0, 18'h1_0777);
    // R4: load with write idle must neither write nor step
    cycle("R4 idle", 1, 0, 0, 18'h0_0FFF);
    cycle("R4 after idle", 1, 1, 0, 18'h0_0555);
    // R5 and R6: normal write leaves thresholds and resets sequencer
    cycle("R5 normal wr", 0, 1, 1, 18'h0_0999);
    cycle("R6 restart", 1, 1, 0, 18'h0_0246);
    // R7: readback in order, same-edge write returns old value
    cycle("R6 release2", 0, 0, 0, '0);
    cycle("R7 rb+wr", 1, 1, 1, 18'h0_0ACE);
    cycle("R7 rb1", 1, 0, 1, '0);
    cycle("R7 rb wrap", 1, 0, 1, '0);
    // R8: hold readback
    cycle("R8 hold", 0, 1, 1, '0);
    cycle("R8 hold2", 1, 1, 0, 18'h0_0001);
    for (int i = 0; i < 600; i++) begin
      bit l;
      l = ($urandom_range(0, 9) < 7);
      cycle("RAND", l, 1'($urandom()), 1'($urandom()), DATA_W'($urandom()));
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5.0);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule